// File: doc/BRIEF.md
# AES32 Decryption Step Unit

This unit executes the two scalar 32-bit AES decryption step instructions in a single registered stage. Each instruction works on one byte of the second source operand. A 2-bit lane field in the instruction word picks that byte. The byte goes through the inverse AES substitution. For the middle-round variant, the substituted byte is then expanded into a 32-bit partial inverse column-mix word. The result is rotated back into the chosen lane and XOR-accumulated into the first source operand.

The unit receives the raw instruction word with a valid strobe and both source register values. On the clock edge after the strobe it presents a result bundle: a valid flag, an illegal flag, the variant flag, the destination register index and the 32-bit destination value. Four issues of the same variant, one per lane, make up one full decryption column step. The register file and hazard handling stay outside the unit.

Top module: `aes32_dec_step`

## Requirements
- R1: A word whose bits masked with 0x3e00707f equal 0x2a000033 is a legal final-round step. That means opcode [6:0]=0110011, funct3 [14:12]=000 and funct5 [29:25]=10101, with bits [31:30] (lane select) and the three register fields not compared. It gives res_illegal=0 and res_is_mid=0.
- R2: A word whose masked bits equal 0x2e000033 (funct5 10111, other fixed fields as in R1) is a legal middle-round step. It gives res_illegal=0 and res_is_mid=1.
- R3: For a final-round step with lane s = instr[31:30], the unit takes byte s of rs2_val (bits 8s+7..8s) and applies the inverse substitution. It zero-extends the result to 32 bits, rotates it left by 8s and XORs it with rs1_val to form res_data.
- R4: For a middle-round step, the substituted byte y is first expanded to the word {y·0x0b, y·0x0d, y·0x09, y·0x0e}, most significant byte first. The products are in GF(2^8) modulo x^8+x^4+x^3+x+1. The word is then rotated left by 8s and XORed with rs1_val.
- R5: The substitution is the standard AES inverse S-box; for example 0x00 maps to 0x52 and 0x63 maps to 0x00.
- R6: res_rd equals instr[11:7] for every legal step, whatever the rs1 field instr[19:15] holds; rd different from rs1 is legal.
- R7: A strobed word that matches neither pattern gives res_valid=1 and res_illegal=1, with res_data, res_rd and res_is_mid all zero.
- R8: The result appears on the clock edge that follows the in_valid cycle. After a cycle without in_valid, all outputs are zero.
- R9: While rst_n is low, all outputs are zero, even if in_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Accumulator source value |
| rs2_val | input | 32 | Byte source value |
| res_valid | output | 1 | Result present this cycle |
| res_illegal | output | 1 | Strobed word was not a decryption step |
| res_is_mid | output | 1 | 1 for middle-round step, 0 for final-round step |
| res_rd | output | 5 | Destination register index |
| res_data | output | 32 | Destination value |

## Verification
On every cycle the assertions check the timing and handshake rules. A strobe must produce a result one cycle later, and an idle cycle must leave the outputs quiet. An illegal result must carry zero fields, each variant must be flagged correctly, and the destination index must track the rd field. They also check that a final-round step changes rs1 only inside the selected lane. The actual byte values can only be shown by the bench's scenarios. These are the inverse substitution, the GF(2^8) expansion and the rotation into each of the four lanes. The bench compares them against an independently built reference table over fixed and random operands.

// File: rtl/aesd_pkg.sv
package aesd_pkg;

    localparam int XW    = 32;
    localparam int BW    = 8;
    localparam int LANES = XW / BW;
    localparam int SELW  = $clog2(LANES);
    localparam int REGW  = 5;

    localparam logic [XW-1:0] STEP_MASK   = 32'h3e00707f;
    localparam logic [XW-1:0] MATCH_FINAL = 32'h2a000033;
    localparam logic [XW-1:0] MATCH_MID   = 32'h2e000033;

    // per-lane multipliers of the partial inverse column mix, lane 0 lowest
    localparam logic [XW-1:0] MIX_COEF = 32'h0b0d090e;

    typedef struct packed {
        logic            vld;
        logic            ill;
        logic            mid;
        logic [REGW-1:0] rd;
        logic [XW-1:0]   data;
    } resp_t;

    function automatic logic [BW-1:0] gf_xtime(input logic [BW-1:0] a);
        return {a[BW-2:0], 1'b0} ^ (a[BW-1] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [BW-1:0] gf_mul(input logic [BW-1:0] a,
                                             input logic [BW-1:0] b);
        logic [BW-1:0] acc;
        logic [BW-1:0] t;
        acc = '0;
        t   = a;
        for (int i = 0; i < BW; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xtime(t);
        end
        return acc;
    endfunction

    // a^254 by repeated squaring: product of a^2, a^4, ..., a^128
    function automatic logic [BW-1:0] gf_inv(input logic [BW-1:0] a);
        logic [BW-1:0] sq;
        logic [BW-1:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 1; i < BW; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] inv_affine(input logic [BW-1:0] y);
        return {y[6:0], y[7]} ^ {y[4:0], y[7:5]} ^ {y[1:0], y[7:2]} ^ 8'h05;
    endfunction

endpackage

// File: rtl/aesd_decode.sv
module aesd_decode
    import aesd_pkg::*;
(
    input  logic [XW-1:0]   instr_i,
    output logic            hit_o,
    output logic            mid_o,
    output logic [SELW-1:0] sel_o,
    output logic [REGW-1:0] rd_o
);
    logic [XW-1:0] masked;
    logic          is_final;
    logic          is_mid;

    assign masked   = instr_i & STEP_MASK;
    assign is_final = (masked == MATCH_FINAL);
    assign is_mid   = (masked == MATCH_MID);

    assign hit_o = is_final | is_mid;
    assign mid_o = is_mid;
    assign sel_o = instr_i[XW-1 -: SELW];
    assign rd_o  = instr_i[7 +: REGW];
endmodule

// File: rtl/aesd_invsbox.sv
module aesd_invsbox
    import aesd_pkg::*;
(
    input  logic [BW-1:0] byte_i,
    output logic [BW-1:0] byte_o
);
    logic [BW-1:0] pre;

    assign pre    = inv_affine(byte_i);
    assign byte_o = gf_inv(pre);
endmodule

// File: rtl/aesd_mixword.sv
module aesd_mixword
    import aesd_pkg::*;
(
    input  logic [BW-1:0] byte_i,
    output logic [XW-1:0] word_o
);
    for (genvar j = 0; j < LANES; j++) begin : g_coef
        assign word_o[j*BW +: BW] = gf_mul(byte_i, MIX_COEF[j*BW +: BW]);
    end
endmodule

// File: rtl/aesd_rotl.sv
module aesd_rotl
    import aesd_pkg::*;
(
    input  logic [XW-1:0]   word_i,
    input  logic [SELW-1:0] sel_i,
    output logic [XW-1:0]   word_o
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [SELW-1:0] src;
        assign src = SELW'(j) - sel_i;
        assign word_o[j*BW +: BW] = word_i[src*BW +: BW];
    end
endmodule

// File: rtl/aes32_dec_step.sv
module aes32_dec_step
    import aesd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XW-1:0]   instr,
    input  logic [XW-1:0]   rs1_val,
    input  logic [XW-1:0]   rs2_val,
    output logic            res_valid,
    output logic            res_illegal,
    output logic            res_is_mid,
    output logic [REGW-1:0] res_rd,
    output logic [XW-1:0]   res_data
);
    logic            dec_hit;
    logic            dec_mid;
    logic [SELW-1:0] dec_sel;
    logic [REGW-1:0] dec_rd;
    logic [BW-1:0]   lane_byte;
    logic [BW-1:0]   sub_byte;
    logic [XW-1:0]   mix_word;
    logic [XW-1:0]   pre_rot;
    logic [XW-1:0]   rot_word;
    resp_t           resp_d;
    resp_t           resp_q;

    aesd_decode u_dec (
        .instr_i (instr),
        .hit_o   (dec_hit),
        .mid_o   (dec_mid),
        .sel_o   (dec_sel),
        .rd_o    (dec_rd)
    );

    assign lane_byte = rs2_val[dec_sel*BW +: BW];

    aesd_invsbox u_sbox (
        .byte_i (lane_byte),
        .byte_o (sub_byte)
    );

    aesd_mixword u_mix (
        .byte_i (sub_byte),
        .word_o (mix_word)
    );

    assign pre_rot = dec_mid ? mix_word : {{(XW-BW){1'b0}}, sub_byte};

    aesd_rotl u_rot (
        .word_i (pre_rot),
        .sel_i  (dec_sel),
        .word_o (rot_word)
    );

    always_comb begin
        resp_d = '0;
        if (in_valid) begin
            resp_d.vld = 1'b1;
            if (dec_hit) begin
                resp_d.mid  = dec_mid;
                resp_d.rd   = dec_rd;
                resp_d.data = rs1_val ^ rot_word;
            end else begin
                resp_d.ill = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign res_valid   = resp_q.vld;
    assign res_illegal = resp_q.ill;
    assign res_is_mid  = resp_q.mid;
    assign res_rd      = resp_q.rd;
    assign res_data    = resp_q.data;
endmodule

// File: rtl/aesd_check.sv
module aesd_check
    import aesd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XW-1:0]   instr,
    input logic [XW-1:0]   rs1_val,
    input logic            res_valid,
    input logic            res_illegal,
    input logic            res_is_mid,
    input logic [REGW-1:0] res_rd,
    input logic [XW-1:0]   res_data
);
    logic fin_hit;
    logic mid_hit;
    assign fin_hit = ((instr & STEP_MASK) == MATCH_FINAL);
    assign mid_hit = ((instr & STEP_MASK) == MATCH_MID);

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !res_illegal && !res_is_mid
                       && res_rd == '0 && res_data == '0));

    a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (res_valid && !res_is_mid && res_rd == '0 && res_data == '0));

    a_r1_final_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fin_hit) |=> (!res_illegal && !res_is_mid &&
            (((res_data ^ $past(rs1_val)) & ~(32'hff << ($past(instr[31:30]) * 8))) == '0)));

    a_r2_mid_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mid_hit) |=> (res_is_mid && !res_illegal));

    a_r6_rd_field: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (fin_hit || mid_hit)) |=> (res_rd == $past(instr[11:7])));
endmodule

bind aes32_dec_step aesd_check u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .rs1_val     (rs1_val),
    .res_valid   (res_valid),
    .res_illegal (res_illegal),
    .res_is_mid  (res_is_mid),
    .res_rd      (res_rd),
    .res_data    (res_data)
);

// File: tb/sim_aes32_dec_step.sv
`timescale 1ns/1ps
module sim_aes32_dec_step;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic        res_valid, res_illegal, res_is_mid;
    logic [4:0]  res_rd;
    logic [31:0] res_data;

    always #2 clk = ~clk;

    aes32_dec_step u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .res_valid(res_valid),
        .res_illegal(res_illegal), .res_is_mid(res_is_mid),
        .res_rd(res_rd), .res_data(res_data)
    );

    typedef struct {
        logic        vld;
        logic        ill;
        logic        mid;
        logic [4:0]  rd;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     errors = 0;
    bit     started = 0;
    bit     done = 0;
    logic [7:0] inv_tab [256];

    // reference arithmetic built with xtime-by-shift and brute-force inverse
    function automatic logic [7:0] r_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] rotb(input logic [7:0] v, input int n);
        logic [15:0] w = {v, v} << n;
        return w[15:8];
    endfunction

    task automatic build_table();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv = 8'h00;
            logic [7:0] s;
            for (int y = 1; y < 256; y++)
                if (r_mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            s = iv ^ rotb(iv, 1) ^ rotb(iv, 2) ^ rotb(iv, 3) ^ rotb(iv, 4) ^ 8'h63;
            inv_tab[s] = 8'(x);
        end
    endtask

    function automatic logic [31:0] enc(input logic [1:0] bs, input logic [4:0] f5,
                                        input logic [4:0] r2, input logic [4:0] r1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
        return {bs, f5, r2, r1, f3, rd, op};
    endfunction

    function automatic exp_t model(input logic v, input logic [31:0] w,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input string tag);
        exp_t e;
        logic [1:0]  s = w[31:30];
        logic [7:0]  y = inv_tab[b[8*s +: 8]];
        logic [31:0] word;
        logic [63:0] dbl;
        bit legal_op = (w[6:0] == 7'b0110011) && (w[14:12] == 3'b000);
        e.vld = v; e.ill = 0; e.mid = 0; e.rd = '0; e.data = '0; e.tag = tag;
        if (!v) return e;
        if (legal_op && (w[29:25] == 5'b10101 || w[29:25] == 5'b10111)) begin
            e.mid = (w[29:25] == 5'b10111);
            word = e.mid ? {r_mul(y, 8'h0b), r_mul(y, 8'h0d), r_mul(y, 8'h09), r_mul(y, 8'h0e)}
                         : {24'h0, y};
            dbl = {word, word} << (8 * s);
            e.rd = w[11:7];
            e.data = a ^ dbl[63:32];
        end else begin
            e.ill = 1;
        end
        return e;
    endfunction

    task automatic issue(input logic v, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        @(negedge clk);
        in_valid = v; instr = w; rs1_val = a; rs2_val = b;
        sb.push_back(model(v, w, a, b, tag));
    endtask

    task automatic compare(input exp_t e);
        checks++;
        if (res_valid !== e.vld || res_illegal !== e.ill || res_is_mid !== e.mid ||
            res_rd !== e.rd || res_data !== e.data) begin
            errors++;
            $display("FAIL %s: got v=%b i=%b m=%b rd=%0d data=%h expected v=%b i=%b m=%b rd=%0d data=%h",
                     e.tag, res_valid, res_illegal, res_is_mid, res_rd, res_data,
                     e.vld, e.ill, e.mid, e.rd, e.data);
        end
    endtask

    // monitor
    initial begin
        wait (started);
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t z;
        build_table();
        z = model(1'b0, '0, '0, '0, "R9 reset");
        // R9: reset holds outputs at zero even with a strobe present
        in_valid = 1; instr = enc(2'd1, 5'b10111, 5'd3, 5'd4, 3'b000, 5'd9, 7'h33);
        rs1_val = 32'h1234_5678; rs2_val = 32'h9abc_def0;
        repeat (3) @(posedge clk);
        #1 compare(z);
        @(negedge clk);
        in_valid = 0;
        rst_n = 1;
        started = 1;

        // R5: known table points through the final-round path
        issue(1, enc(2'd0, 5'b10101, 5'd2, 5'd1, 3'b000, 5'd1, 7'h33), 32'h0, 32'h0000_0000, "R5 0x00");
        issue(1, enc(2'd2, 5'b10101, 5'd2, 5'd1, 3'b000, 5'd1, 7'h33), 32'h0, 32'h0063_0000, "R5 0x63");
        // R3 and R4: every lane, both variants
        for (int s = 0; s < 4; s++) begin
            issue(1, enc(2'(s), 5'b10101, 5'd6, 5'd5, 3'b000, 5'd5, 7'h33),
                  32'hdead_beef, 32'h0123_4567, "R3 lane");
            issue(1, enc(2'(s), 5'b10111, 5'd6, 5'd5, 3'b000, 5'd5, 7'h33),
                  32'hdead_beef, 32'h89ab_cdef, "R4 lane");
        end
        // R6: rd differs from rs1
        issue(1, enc(2'd3, 5'b10101, 5'd7, 5'd12, 3'b000, 5'd30, 7'h33),
              32'h5555_aaaa, 32'hff00_1122, "R6 rd!=rs1 final");
        issue(1, enc(2'd1, 5'b10111, 5'd7, 5'd2, 3'b000, 5'd17, 7'h33),
              32'h0f0f_0f0f, 32'h00c4_7700, "R6 rd!=rs1 mid");
        // R8: idle gap then back-to-back
        issue(0, '0, 32'hffff_ffff, 32'hffff_ffff, "R8 idle");
        issue(0, enc(2'd0, 5'b10101, 5'd1, 5'd1, 3'b000, 5'd1, 7'h33), 32'h1, 32'h2, "R8 idle decoded");
        // R7: illegal encodings
        issue(1, enc(2'd0, 5'b10110, 5'd1, 5'd2, 3'b000, 5'd3, 7'h33), 32'hffff_ffff, 32'h1, "R7 funct5");
        issue(1, enc(2'd1, 5'b10101, 5'd1, 5'd2, 3'b001, 5'd3, 7'h33), 32'hffff_ffff, 32'h1, "R7 funct3");
        issue(1, enc(2'd2, 5'b10111, 5'd1, 5'd2, 3'b000, 5'd3, 7'h13), 32'hffff_ffff, 32'h1, "R7 opcode");
        // R1 and R2: random operands, fields and lanes
        for (int k = 0; k < 200; k++) begin
            logic [31:0] r = $urandom;
            issue(1, enc(r[1:0], r[2] ? 5'b10111 : 5'b10101, r[7:3], r[12:8], 3'b000, r[17:13], 7'h33),
                  $urandom, $urandom, r[2] ? "R2 random mid" : "R1 random final");
        end
        issue(0, '0, '0, '0, "R8 drain");
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        #1;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule